// File: doc/BRIEF.md
# In-System Programming Enable Sequencer

This block is the master side of the entry step into a target microcontroller's serial programming mode. A single-cycle start pulse makes it raise the target's reset line. It then keeps the serial clock low for a settling time measured in target clocks. After that it runs a full-duplex SPI exchange of four bytes. While each command byte goes out, the byte on the return line is shifted in. The reply from the last transfer is compared with a fixed confirmation value.

All serial timing is derived from one parameter, `CLK_RATIO`, the number of master clocks per target clock. The settling hold and every serial clock phase get one extra master cycle beyond the target's minimum. A correct reply gives a one-cycle done pulse. A wrong reply raises a sticky error flag. The final reply byte stays visible on an output in both cases. Later commands such as program, read and erase are left to other logic; the target reset stays asserted so that a programming session can follow.

Top module: `isp_enable_master`

## Requirements
- R1: After `rst_ni` is released, `tgt_rst_o`, `sck_o`, `mosi_o`, `done_o` and `err_o` are all 0, `rx_byte_o` is 0x00, and the block stays idle with no serial clock activity until a start is accepted.
- R2: A start accepted in idle drives `tgt_rst_o` high on the next clock edge. It then stays high, through done and error, until `rst_ni` is asserted.
- R3: After a start is accepted, `sck_o` stays low for at least 64*`CLK_RATIO` master cycles before its first rising edge.
- R4: Every high phase and every low phase of `sck_o` during a transfer lasts at least 8*`CLK_RATIO` master cycles.
- R5: Each byte goes out on `mosi_o` with the most significant bit first. Each bit is in place before `sck_o` rises and does not change while `sck_o` is high.
- R6: One session sends exactly four bytes, in the order 0xAC, 0x53, 0xFF, 0xFF, which is 32 rising edges of `sck_o`. `sck_o` is low between bytes and after the last byte.
- R7: `miso_i` is sampled at each rising edge of `sck_o`, most significant bit first. When done or error is reported, `rx_byte_o` holds the byte received during the fourth transfer.
- R8: If the fourth received byte equals 0x69, `done_o` is high for exactly one cycle and `err_o` stays 0.
- R9: If the fourth received byte is any value other than 0x69, `err_o` goes high and `done_o` stays 0. `err_o` holds until the next accepted start and is 0 from the edge that accepts it.
- R10: A start pulse that arrives while a session is running is ignored. The session finishes with exactly four bytes and a single outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| done_o | output | 1 | One-cycle pulse on a confirmed enable |
| err_o | output | 1 | Sticky flag for a failed enable |
| rx_byte_o | output | 8 | Byte received in the fourth transfer |
| tgt_rst_o | output | 1 | Target reset line |
| sck_o | output | 1 | Serial clock to the target |
| mosi_o | output | 1 | Serial data to the target |
| miso_i | input | 1 | Serial data from the target |

## Verification
A bench model of the target drives a scripted reply byte for each transfer and records the command bits it sees. The scripts are chosen to separate the failure modes:
- A reply of 0x69 in the last slot checks the success path.
- 0x96, the bit-reverse of 0x69, would pass if the receive order were wrong.
- 0x69 placed only in the third slot would pass if the wrong transfer were checked.
- 0x68 checks that a single-bit miss is rejected.

A session with a start pulse injected mid-transfer checks that the block ignores it. Repeated sessions without a master reset check that the reset line stays asserted and that the error flag clears when the next start is accepted.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int unsigned HOLD_TCLK    = 64;  // target clocks with SCK low after reset
  localparam int unsigned HALF_TCLK    = 8;   // target clocks per SCK phase
  localparam int unsigned NUM_CMD      = 4;
  localparam int unsigned BYTE_W       = 8;
  localparam logic [7:0]  CONFIRM_BYTE = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOW,
    ST_HIGH,
    ST_CHECK
  } seq_state_e;

  function automatic logic [7:0] cmd_byte(input int unsigned idx);
    case (idx)
      0:       return 8'hAC;
      1:       return 8'h53;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/isp_timer.sv
module isp_timer #(
  parameter int unsigned HOLD_CYC = 129,
  parameter int unsigned HALF_CYC = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_hold_i,
  input  logic load_half_i,
  output logic expired_o
);

  localparam int unsigned MAX_CYC = (HOLD_CYC > HALF_CYC) ? HOLD_CYC : HALF_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  // phase after a load lasts exactly the loaded cycle count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_hold_i) begin
      cnt_q <= HOLD_LD;
    end else if (load_half_i) begin
      cnt_q <= HALF_LD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/isp_shift.sv
module isp_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         sample_i,
  input  logic         advance_i,
  input  logic         miso_i,
  output logic         tx_bit_o,
  output logic         last_bit_o,
  output logic [W-1:0] rx_data_o
);

  localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic [W-1:0]  tx_q;
  logic [W-1:0]  rx_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      bit_q <= '0;
    end else if (advance_i) begin
      tx_q  <= {tx_q[W-2:0], 1'b0};
      bit_q <= bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (sample_i) begin
      rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign tx_bit_o   = tx_q[W-1];
  assign last_bit_o = (bit_q == LAST);
  assign rx_data_o  = rx_q;

endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       expired_i,
  input  logic       last_bit_i,
  input  logic       tx_bit_i,
  input  logic [7:0] rx_data_i,
  output logic       load_hold_o,
  output logic       load_half_o,
  output logic       sh_load_o,
  output logic [7:0] sh_data_o,
  output logic       sh_sample_o,
  output logic       sh_advance_o,
  output logic       tgt_rst_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rx_byte_o
);

  localparam int unsigned IW = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CMD - 1);

  seq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q;
  logic          rst_q, sck_q, done_q, err_q;
  logic [7:0]    rx_byte_q;
  logic          accept, phase_end, byte_end, seq_end;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign phase_end = expired_i;
  assign byte_end  = (state_q == ST_HIGH) && phase_end && last_bit_i;
  assign seq_end   = byte_end && (idx_q == LAST_IDX);

  always_comb begin
    state_d      = state_q;
    load_hold_o  = 1'b0;
    load_half_o  = 1'b0;
    sh_load_o    = 1'b0;
    sh_data_o    = cmd_byte(int'(idx_q));
    sh_sample_o  = 1'b0;
    sh_advance_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d     = ST_HOLD;
          load_hold_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (phase_end) begin
          state_d     = ST_LOW;
          load_half_o = 1'b1;
          sh_load_o   = 1'b1;
          sh_data_o   = cmd_byte(0);
        end
      end
      ST_LOW: begin
        if (phase_end) begin
          state_d     = ST_HIGH;
          load_half_o = 1'b1;
          sh_sample_o = 1'b1;
        end
      end
      ST_HIGH: begin
        if (phase_end) begin
          if (!last_bit_i) begin
            state_d      = ST_LOW;
            load_half_o  = 1'b1;
            sh_advance_o = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_CHECK;
          end else begin
            state_d     = ST_LOW;
            load_half_o = 1'b1;
            sh_load_o   = 1'b1;
            sh_data_o   = cmd_byte(int'(idx_q) + 1);
          end
        end
      end
      ST_CHECK: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      rst_q     <= 1'b0;
      sck_q     <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      rx_byte_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (accept) begin
        rst_q <= 1'b1;
        err_q <= 1'b0;
        idx_q <= '0;
      end
      if ((state_q == ST_LOW) && phase_end) begin
        sck_q <= 1'b1;
      end
      if ((state_q == ST_HIGH) && phase_end) begin
        sck_q <= 1'b0;
      end
      if (byte_end && !seq_end) begin
        idx_q <= idx_q + 1'b1;
      end
      if (state_q == ST_CHECK) begin
        rx_byte_q <= rx_data_i;
        if (rx_data_i == CONFIRM_BYTE) begin
          done_q <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign tgt_rst_o = rst_q;
  assign sck_o     = sck_q;
  assign mosi_o    = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && tx_bit_i;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rx_byte_o = rx_byte_q;

endmodule

// File: rtl/isp_enable_master.sv
module isp_enable_master
  import isp_pkg::*;
#(
  parameter int unsigned CLK_RATIO = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rx_byte_o,
  output logic       tgt_rst_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);

  // one extra master cycle of margin on every target-clock minimum
  localparam int unsigned HOLD_CYC = HOLD_TCLK * CLK_RATIO + 1;
  localparam int unsigned HALF_CYC = HALF_TCLK * CLK_RATIO + 1;

  logic       load_hold, load_half, expired;
  logic       sh_load, sh_sample, sh_advance;
  logic [7:0] sh_data, rx_data;
  logic       tx_bit, last_bit;

  isp_timer #(
    .HOLD_CYC(HOLD_CYC),
    .HALF_CYC(HALF_CYC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_hold_i(load_hold),
    .load_half_i(load_half),
    .expired_o  (expired)
  );

  isp_shift #(
    .W(BYTE_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_data_i(sh_data),
    .sample_i   (sh_sample),
    .advance_i  (sh_advance),
    .miso_i     (miso_i),
    .tx_bit_o   (tx_bit),
    .last_bit_o (last_bit),
    .rx_data_o  (rx_data)
  );

  isp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .expired_i   (expired),
    .last_bit_i  (last_bit),
    .tx_bit_i    (tx_bit),
    .rx_data_i   (rx_data),
    .load_hold_o (load_hold),
    .load_half_o (load_half),
    .sh_load_o   (sh_load),
    .sh_data_o   (sh_data),
    .sh_sample_o (sh_sample),
    .sh_advance_o(sh_advance),
    .tgt_rst_o   (tgt_rst_o),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rx_byte_o   (rx_byte_o)
  );

endmodule

// File: rtl/isp_enable_checker.sv
module isp_enable_checker #(
  parameter int unsigned CLK_RATIO = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       tgt_rst_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       done_o,
  input logic       err_o,
  input logic [7:0] rx_byte_o
);

  localparam int unsigned MIN_HOLD = 64 * CLK_RATIO;
  localparam int unsigned MIN_HALF = 8 * CLK_RATIO;

  logic        sck_d, mosi_d, rst_d, first_pend;
  logic [15:0] phase_cnt, arm_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d      <= 1'b0;
      mosi_d     <= 1'b0;
      rst_d      <= 1'b0;
      first_pend <= 1'b0;
      phase_cnt  <= '0;
      arm_cnt    <= '0;
    end else begin
      sck_d  <= sck_o;
      mosi_d <= mosi_o;
      rst_d  <= tgt_rst_o;
      if (sck_o != sck_d) phase_cnt <= 16'd1;
      else if (phase_cnt != 16'hFFFF) phase_cnt <= phase_cnt + 1'b1;
      if (tgt_rst_o && !rst_d) begin
        first_pend <= 1'b1;
        arm_cnt    <= 16'd1;
      end else begin
        if (arm_cnt != 16'hFFFF) arm_cnt <= arm_cnt + 1'b1;
        if (sck_o && !sck_d) first_pend <= 1'b0;
      end
    end
  end

  // R2
  a_r2_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_rst_o |=> tgt_rst_o);
  // R3
  a_r3_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_pend && sck_o && !sck_d) |-> (arm_cnt >= MIN_HOLD));
  // R4
  a_r4_min_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != sck_d) |-> (phase_cnt >= MIN_HALF));
  // R5
  a_r5_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && sck_d) |-> (mosi_o == mosi_d));
  // R6
  a_r6_sck_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || $rose(err_o)) |-> !sck_o);
  // R8
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rx_byte_o == 8'h69 && !err_o));
  // R9
  a_r9_err_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (rx_byte_o != 8'h69));
  a_r9_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

endmodule

bind isp_enable_master isp_enable_checker #(.CLK_RATIO(CLK_RATIO)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .tgt_rst_o(tgt_rst_o),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .done_o   (done_o),
  .err_o    (err_o),
  .rx_byte_o(rx_byte_o)
);

// File: tb/isp_enable_master_bench.sv
module isp_enable_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_RATIO = 2;
  localparam int MIN_HOLD = 64 * CLK_RATIO;
  localparam int MIN_HALF = 8 * CLK_RATIO;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       miso = 1'b0;
  logic       done, err, tgt_rst, sck, mosi;
  logic [7:0] rx_byte;

  int tests = 0;
  int fails = 0;

  isp_enable_master #(.CLK_RATIO(CLK_RATIO)) u_isp_enable_master (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .done_o   (done),
    .err_o    (err),
    .rx_byte_o(rx_byte),
    .tgt_rst_o(tgt_rst),
    .sck_o    (sck),
    .mosi_o   (mosi),
    .miso_i   (miso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard queue of expected command bytes
  logic [7:0] exp_q[$];
  logic [7:0] reply [4];
  int   s_bit, s_byte, bytes_seen, done_pulses, mosi_bad;
  int   cyc, last_edge, arm_cyc, hold_len, min_low, min_high;
  bit   first_rise;
  logic sck_prev, mosi_at_rise;
  logic [7:0] s_shift;

  // target model and monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done) done_pulses++;
      if (sck && !sck_prev) begin
        if (first_rise) begin
          hold_len   = cyc - arm_cyc;
          first_rise = 1'b0;
        end else if (cyc - last_edge < min_low) begin
          min_low = cyc - last_edge;
        end
        last_edge    = cyc;
        mosi_at_rise = mosi;
        s_shift      = {s_shift[6:0], mosi};
        if (s_bit == 7) begin
          bytes_seen++;
          if (exp_q.size() > 0) check("R6 command byte", 32'(s_shift), 32'(exp_q.pop_front()));
          else check("R6 extra byte", 32'(s_shift), 32'hFFFF_FFFF);
        end
      end else if (!sck && sck_prev) begin
        if (cyc - last_edge < min_high) min_high = cyc - last_edge;
        last_edge = cyc;
        s_bit++;
        if (s_bit == 8) begin
          s_bit = 0;
          s_byte++;
        end
        if (s_byte < 4) miso = reply[s_byte][7 - s_bit];
      end else if (sck && sck_prev && mosi !== mosi_at_rise) begin
        mosi_bad++;
      end
      sck_prev = sck;
    end else begin
      sck_prev = 1'b0;
    end
  end

  task automatic run_session(input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2,
                             input logic [7:0] r3, input bit exp_ok, input bit poke_mid);
    int n;
    reply[0] = r0; reply[1] = r1; reply[2] = r2; reply[3] = r3;
    s_bit = 0; s_byte = 0; bytes_seen = 0; done_pulses = 0; mosi_bad = 0;
    min_low = 1 << 30; min_high = 1 << 30; hold_len = 0;
    miso = r0[7];
    exp_q.push_back(8'hAC); exp_q.push_back(8'h53);
    exp_q.push_back(8'hFF); exp_q.push_back(8'hFF);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    arm_cyc = cyc; first_rise = 1'b1;
    check("R2 reset line high after start", 32'(tgt_rst), 32'd1);
    check("R9 error cleared by start", 32'(err), 32'd0);
    n = 0;
    while (!(done || err) && n < 5000) begin
      @(negedge clk);
      n++;
      start = (poke_mid && n == 400) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    check("R3 hold before first rise", 32'(hold_len >= MIN_HOLD), 32'd1);
    check("R4 low phase length", 32'(min_low >= MIN_HALF), 32'd1);
    check("R4 high phase length", 32'(min_high >= MIN_HALF), 32'd1);
    check("R5 mosi stable while sck high", 32'(mosi_bad), 32'd0);
    check("R6 bytes per session", 32'(bytes_seen), 32'd4);
    check("R6 all commands seen", 32'(exp_q.size()), 32'd0);
    check("R6 sck low at end", 32'(sck), 32'd0);
    check("R7 fourth reply on output", 32'(rx_byte), 32'(r3));
    check("R2 reset line still high", 32'(tgt_rst), 32'd1);
    if (exp_ok) begin
      check("R8 done on match", 32'(done), 32'd1);
      check("R8 no error on match", 32'(err), 32'd0);
      @(negedge clk);
      check("R8 done lasts one cycle", 32'(done), 32'd0);
      repeat (40) @(negedge clk);
      check("R10 single outcome", 32'(done_pulses), 32'd1);
    end else begin
      check("R9 error on mismatch", 32'(err), 32'd1);
      repeat (60) @(negedge clk);
      check("R9 error held", 32'(err), 32'd1);
      check("R9 no done on mismatch", 32'(done_pulses), 32'd0);
    end
    exp_q.delete();
  endtask

  initial begin
    sck_prev = 1'b0; cyc = 0; last_edge = 0; first_rise = 1'b0;
    s_bit = 0; s_byte = 0; s_shift = '0; mosi_at_rise = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset line low", 32'(tgt_rst), 32'd0);
    check("R1 sck low", 32'(sck), 32'd0);
    check("R1 mosi low", 32'(mosi), 32'd0);
    check("R1 done low", 32'(done), 32'd0);
    check("R1 error low", 32'(err), 32'd0);
    check("R1 rx byte zero", 32'(rx_byte), 32'd0);
    repeat (30) @(negedge clk);
    check("R1 idle without start", 32'({tgt_rst, sck, mosi}), 32'd0);

    run_session(8'h00, 8'h00, 8'h00, 8'h69, 1'b1, 1'b0);  // plain success
    run_session(8'h12, 8'h34, 8'h56, 8'h96, 1'b0, 1'b0);  // R7 reversed order rejected
    run_session(8'hFF, 8'hFF, 8'hFF, 8'h69, 1'b1, 1'b1);  // R10 start mid-session ignored
    run_session(8'h00, 8'h00, 8'h69, 8'h00, 1'b0, 1'b0);  // R7 third byte not checked
    run_session(8'h69, 8'h69, 8'h69, 8'h68, 1'b0, 1'b0);  // R9 single-bit miss
    run_session(8'hA5, 8'h5A, 8'hC3, 8'h69, 1'b1, 1'b0);  // R9 clear then success

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule